// File: doc/BRIEF.md
# Configurable Registered Logic Macrocell

This block is a single output cell of a small programmable logic array. One sum-of-products term comes in from the term allocator. Static configuration inputs decide how the cell treats that term. In pass-through mode the term goes directly to the output. In stored mode it goes through one flip-flop, which captures the term as a data input or toggles when the term is high. In both modes an optional inversion is applied last.

The flip-flop is clocked by one of several global clock lines, picked by a small select field. Two block-wide terms initialise every flip-flop in the array together, without waiting for a clock edge: one clears the flip-flop and the other sets it. The cell sends its final value to a pin driver. It also sends the same value back to the routing fabric, so the logic stays usable when the pin is not driven.

Configuration is treated as static. It is changed only while the clear term is held.

Top module: `macrocell_unit`

## Requirements
- R1: With `cfg_registered`=0, `to_io` equals `sum_in` XOR `cfg_invert` at all times, whatever the clock lines do.
- R2: With `cfg_registered`=1, `to_io` equals the stored bit XOR `cfg_invert`; the inversion is applied after the flip-flop.
- R3: With `cfg_registered`=1 and `cfg_toggle`=0, a rising edge on the selected clock stores `sum_in`.
- R4: With `cfg_registered`=1 and `cfg_toggle`=1, a rising edge on the selected clock inverts the stored bit when `sum_in`=1 and keeps it when `sum_in`=0.
- R5: The selected clock is `gclk[cfg_clk_sel]`, with select value 0 to 3 naming lines 0 to 3. Rising edges on the other clock lines leave the stored bit unchanged.
- R6: `ar_in`=1 clears the stored bit and `ap_in`=1 sets it, immediately and with no clock edge.
- R7: If `ar_in` and `ap_in` are both 1, the clear takes precedence. After both are released together, the stored bit reads 0.
- R8: `fb_out` equals `to_io` in both pass-through and stored modes.
- R9: Once initialisation is released, the stored bit keeps its value while `sum_in` changes, until a rising edge arrives on the selected clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk | input | 4 | Global clock lines |
| ar_in | input | 1 | Block-wide asynchronous clear term, active high |
| ap_in | input | 1 | Block-wide asynchronous set term, active high |
| sum_in | input | 1 | Sum-of-products term from the allocator |
| cfg_registered | input | 1 | 1 = stored mode, 0 = pass-through |
| cfg_toggle | input | 1 | 1 = toggle flip-flop, 0 = data flip-flop |
| cfg_invert | input | 1 | 1 = invert the output |
| cfg_clk_sel | input | 2 | Index of the clock line that clocks the flip-flop |
| to_io | output | 1 | Value sent to the pin driver |
| fb_out | output | 1 | Value sent back to the routing fabric |

## Verification
The stored-mode sweep covers every clock select, flip-flop kind, polarity and starting state (cleared or set). For each combination it applies an eight-step term sequence that contains runs of ones and runs of zeros. The runs of ones tell toggle behaviour apart from data capture, and starting from both the set and cleared states catches an output inversion placed before the flip-flop. Between the steps, every unselected clock line is pulsed with the term that would move the flip-flop. This exposes a wrong clock index or a leak from a neighbouring clock. Separate patterns cover both initialisation terms held together, term changes with no clock edge, and every term and polarity pair in pass-through mode.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef struct packed {
        logic       registered;
        logic       toggle;
        logic       invert;
        logic [1:0] clk_sel;
    } mc_cfg_t;

    typedef enum logic [1:0] {
        ST_PASS   = 2'b00,
        ST_DATA   = 2'b01,
        ST_TOGGLE = 2'b10
    } mc_kind_e;

    function automatic mc_kind_e mc_kind(input mc_cfg_t c);
        if (!c.registered)
            return ST_PASS;
        else if (c.toggle)
            return ST_TOGGLE;
        else
            return ST_DATA;
    endfunction

    function automatic logic mc_next(input logic q, input logic s, input logic tmode);
        return tmode ? (q ^ s) : s;
    endfunction

endpackage

// File: rtl/mc_clk_mux.sv
module mc_clk_mux #(
    parameter int NCLK = 4,
    parameter int SELW = (NCLK > 1) ? $clog2(NCLK) : 1
) (
    input  logic [NCLK-1:0] gclk,
    input  logic [SELW-1:0] sel,
    output logic            clk_out
);
    assign clk_out = gclk[sel];
endmodule

// File: rtl/mc_state_reg.sv
module mc_state_reg
    import mc_pkg::*;
(
    input  logic    clk,
    input  logic    clr,
    input  logic    set,
    input  logic    d,
    input  mc_cfg_t cfg,
    output logic    q
);
    logic init;
    logic armed;
    logic nxt;

    assign init = clr | set;
    assign nxt  = mc_next(q, d, mc_kind(cfg) == ST_TOGGLE);

    always_ff @(posedge clk or posedge clr or posedge set) begin
        if (clr)
            q <= 1'b0;
        else if (set)
            q <= 1'b1;
        else
            q <= nxt;
    end

    // marks that an edge of the selected clock occurred since the last initialisation
    always_ff @(posedge clk or posedge init) begin
        if (init)
            armed <= 1'b0;
        else
            armed <= 1'b1;
    end

    // R3: data capture on the selected edge
    a_r3_data_capture: assert property (@(posedge clk) disable iff (init)
        (armed && $past(cfg.registered && !cfg.toggle)) |-> (q == $past(d)));

    // R4: toggle on a high term, hold on a low term
    a_r4_toggle: assert property (@(posedge clk) disable iff (init)
        (armed && $past(cfg.registered && cfg.toggle)) |-> (q == ($past(q) ^ $past(d))));

endmodule

// File: rtl/mc_out_stage.sv
module mc_out_stage
    import mc_pkg::*;
(
    input  logic    sum,
    input  logic    q,
    input  mc_cfg_t cfg,
    output logic    pin_val,
    output logic    fb_val
);
    logic pre;

    always_comb begin
        unique case (mc_kind(cfg))
            ST_PASS: pre = sum;
            default: pre = q;
        endcase
    end

    assign pin_val = pre ^ cfg.invert;
    assign fb_val  = pin_val;
endmodule

// File: rtl/macrocell_unit.sv
module macrocell_unit
    import mc_pkg::*;
#(
    parameter int NCLK = 4,
    localparam int SELW = (NCLK > 1) ? $clog2(NCLK) : 1
) (
    input  logic [NCLK-1:0] gclk,
    input  logic            ar_in,
    input  logic            ap_in,
    input  logic            sum_in,
    input  logic            cfg_registered,
    input  logic            cfg_toggle,
    input  logic            cfg_invert,
    input  logic [SELW-1:0] cfg_clk_sel,
    output logic            to_io,
    output logic            fb_out
);
    mc_cfg_t cfg;
    logic    sel_clk;
    logic    q;

    always_comb begin
        cfg            = '0;
        cfg.registered = cfg_registered;
        cfg.toggle     = cfg_toggle;
        cfg.invert     = cfg_invert;
        cfg.clk_sel    = 2'(cfg_clk_sel);
    end

    mc_clk_mux #(.NCLK(NCLK), .SELW(SELW)) u_mux (
        .gclk    (gclk),
        .sel     (cfg_clk_sel),
        .clk_out (sel_clk)
    );

    mc_state_reg u_reg (
        .clk (sel_clk),
        .clr (ar_in),
        .set (ap_in),
        .d   (sum_in),
        .cfg (cfg),
        .q   (q)
    );

    mc_out_stage u_out (
        .sum     (sum_in),
        .q       (q),
        .cfg     (cfg),
        .pin_val (to_io),
        .fb_val  (fb_out)
    );

    // R1: pass-through path
    a_r1_pass_through: assert property (@(posedge sel_clk) disable iff (ar_in || ap_in)
        !cfg_registered |-> (to_io == (sum_in ^ cfg_invert)));

    // R2: polarity applied after the stored bit
    a_r2_post_polarity: assert property (@(posedge sel_clk) disable iff (ar_in || ap_in)
        cfg_registered |-> (to_io == (q ^ cfg_invert)));

endmodule

// File: tb/macrocell_unit_bench.sv
module macrocell_unit_bench;
    logic       clk = 1'b0;
    logic [3:0] gclk = 4'b0;
    logic       ar_in = 1'b1;
    logic       ap_in = 1'b0;
    logic       sum_in = 1'b0;
    logic       cfg_registered = 1'b0;
    logic       cfg_toggle = 1'b0;
    logic       cfg_invert = 1'b0;
    logic [1:0] cfg_clk_sel = 2'd0;
    logic       to_io;
    logic       fb_out;

    int nvec = 0;
    int nfail = 0;
    int cyc = 0;
    logic exp_q;
    bit done = 1'b0;

    localparam logic [7:0] PAT = 8'b1011_0010;

    macrocell_unit u_macrocell_unit (
        .gclk           (gclk),
        .ar_in          (ar_in),
        .ap_in          (ap_in),
        .sum_in         (sum_in),
        .cfg_registered (cfg_registered),
        .cfg_toggle     (cfg_toggle),
        .cfg_invert     (cfg_invert),
        .cfg_clk_sel    (cfg_clk_sel),
        .to_io          (to_io),
        .fb_out         (fb_out)
    );

    always #4 clk = ~clk;

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            nfail++;
            $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<=100000", cyc);
            finish_run();
        end
    end

    task automatic check(input string tag, input logic got, input logic exp);
        nvec++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: actual=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic pulse(input int idx, input logic s);
        @(negedge clk);
        sum_in = s;
        #1 gclk[idx] = 1'b1;
        #2 gclk[idx] = 1'b0;
        #1;
    endtask

    initial begin
        // reset state: clear held, stored mode, no inversion
        cfg_registered = 1'b1;
        #3;
        check("R6 reset state to_io", to_io, 1'b0);
        check("R8 reset state fb_out", fb_out, 1'b0);

        // stored-mode sweep
        for (int sel = 0; sel < 4; sel++) begin
            for (int tg = 0; tg < 2; tg++) begin
                for (int inv = 0; inv < 2; inv++) begin
                    for (int st = 0; st < 2; st++) begin
                        @(negedge clk);
                        ar_in = 1'b1;
                        cfg_registered = 1'b1;
                        cfg_toggle = tg[0];
                        cfg_invert = inv[0];
                        cfg_clk_sel = sel[1:0];
                        #1;
                        if (st == 1) begin
                            ar_in = 1'b0;
                            ap_in = 1'b1;
                        end
                        #1;
                        exp_q = st[0];
                        check("R6 async init", to_io, exp_q ^ inv[0]);
                        @(negedge clk);
                        ar_in = 1'b0;
                        ap_in = 1'b0;
                        #1;
                        check("R2 after init release", to_io, exp_q ^ inv[0]);
                        for (int k = 0; k < 8; k++) begin
                            for (int j = 0; j < 4; j++) begin
                                if (j != sel) begin
                                    // drive a value that would change the bit
                                    pulse(j, tg[0] ? 1'b1 : ~exp_q);
                                    check("R5 unselected clock ignored", to_io, exp_q ^ inv[0]);
                                end
                            end
                            pulse(sel, PAT[k]);
                            exp_q = tg[0] ? (exp_q ^ PAT[k]) : PAT[k];
                            if (tg[0])
                                check("R4 toggle step", to_io, exp_q ^ inv[0]);
                            else
                                check("R3 data step", to_io, exp_q ^ inv[0]);
                            check("R8 feedback stored", fb_out, exp_q ^ inv[0]);
                        end
                    end
                end
            end
        end

        // R9: term changes without a clock edge
        @(negedge clk);
        ar_in = 1'b1;
        cfg_toggle = 1'b0;
        cfg_invert = 1'b0;
        cfg_clk_sel = 2'd2;
        #2 ar_in = 1'b0;
        for (int k = 0; k < 4; k++) begin
            #2 sum_in = ~sum_in;
            #1 check("R9 hold without edge", to_io, 1'b0);
        end

        // R7: both initialisation terms together
        @(negedge clk);
        ap_in = 1'b1;
        #1 check("R6 set alone", to_io, 1'b1);
        ar_in = 1'b1;
        #1 check("R7 clear wins while both held", to_io, 1'b0);
        ar_in = 1'b0;
        ap_in = 1'b0;
        #1 check("R7 zero after joint release", to_io, 1'b0);
        check("R7 feedback after joint release", fb_out, 1'b0);

        // R1 / R8: pass-through sweep, clocks pulsed to show no effect
        @(negedge clk);
        ar_in = 1'b1;
        cfg_registered = 1'b0;
        #2 ar_in = 1'b0;
        for (int inv = 0; inv < 2; inv++) begin
            cfg_invert = inv[0];
            for (int s = 0; s < 2; s++) begin
                for (int j = 0; j < 4; j++) begin
                    pulse(j, s[0]);
                    check("R1 pass-through", to_io, s[0] ^ inv[0]);
                    check("R8 feedback pass-through", fb_out, s[0] ^ inv[0]);
                end
            end
        end

        done = 1'b1;
        finish_run();
    end
endmodule